// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a 16-bit host register bus reach a small 8-bit PHY register file through two host-visible registers: a command register and a data register. For a write, software first puts the byte in the data register, then writes the command register with the PHY offset and the write bit set. For a read, software writes the command register with the write bit clear. Either command starts a PHY transaction. A busy flag in the command register stays set until the transaction has finished.

On the PHY side the block drives a request strobe, together with an address, a write enable and write data. These are held steady until the PHY answers on a ready input, which may come any number of cycles later. When a read completes, the returned byte is placed in the low bits of the data register. Software polls the busy flag and gives up after a bounded time, roughly a hundred microseconds.

Top module: `phyb_bridge`

## Requirements
- R1: After reset, the command register reads 0x0000, the data register reads 0x0000, and `phy_req` is low.
- R2: A host write at byte offset 0x304 stores all 16 bits into the data register. A later read at 0x304 returns the stored value.
- R3: A read at offset 0x300 returns the command register: bits 7:0 hold the PHY offset, bit 8 the write bit, bit 9 the busy flag, and bits 15:10 read as zero. After an accepted command write, busy reads 1 from the next cycle on.
- R4: A command write with bit 8 set starts a PHY write. `phy_we` is 1, `phy_addr` equals bits 7:0 of the command, and `phy_wdata` equals bits 7:0 of the data register as they were when the command was accepted.
- R5: A command write with bit 8 clear starts a PHY read with `phy_we` at 0. In the cycle after `phy_ready` is sampled, the data register holds `phy_rdata` in bits 7:0 and zero in bits 15:8. If a host write to the data register lands in that same cycle, the read result takes priority.
- R6: `phy_req` rises in the cycle after a command is accepted. It then stays high, with `phy_addr`, `phy_we` and `phy_wdata` unchanged, until the first clock edge at which `phy_ready` is 1. Zero extra wait cycles are allowed.
- R7: Once `phy_ready` has been sampled with `phy_req` high, `phy_req` is low in the next cycle. Busy is still 1 in that cycle and reads 0 one cycle later.
- R8: A command write that arrives while busy is 1 is ignored. No second transaction starts, and the offset and write bit in the command register keep their values.
- R9: A read at any offset other than 0x300 or 0x304 returns 0x0000, and a write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_we | input | 1 | Host access is a write |
| bus_addr | input | 12 | Host byte offset |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for `bus_addr` (combinational) |
| phy_req | output | 1 | PHY transaction request, held until ready |
| phy_we | output | 1 | PHY transaction is a write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write byte |
| phy_rdata | input | 8 | PHY read byte, valid together with ready |
| phy_ready | input | 1 | PHY accepts or completes the request |

## Verification
A corrupted transaction state shows up at the ports within one cycle. The `phy_req` strobe either drops while the PHY is still stalled or stays high after the handshake. The busy bit in the command readback also stops following the one-cycle tail after ready. A wrongly latched offset, write bit or write byte shows on `phy_addr`, `phy_we` or `phy_wdata` in the first request cycle. A stale or misplaced read byte shows in the data readback in the cycle after the handshake. Because of this, the bench compares every output against its model on every clock, using PHY latencies of zero and several cycles.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_TAIL = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/phyb_decode.sv
module phyb_decode #(
    parameter int          AW       = 12,
    parameter logic [11:0] CMD_OFS  = 12'h300,
    parameter logic [11:0] DATA_OFS = 12'h304
) (
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    output logic          cmd_hit,
    output logic          data_hit,
    output logic          cmd_wr,
    output logic          data_wr
);
    localparam logic [AW-1:0] CMD_A  = AW'(CMD_OFS);
    localparam logic [AW-1:0] DATA_A = AW'(DATA_OFS);

    always_comb begin
        cmd_hit  = (bus_addr == CMD_A);
        data_hit = (bus_addr == DATA_A);
        cmd_wr   = bus_sel && bus_we && cmd_hit;
        data_wr  = bus_sel && bus_we && data_hit;
    end
endmodule

// File: rtl/phyb_xfer_fsm.sv
module phyb_xfer_fsm
    import phyb_pkg::*;
#(
    parameter int PAW = 8,
    parameter int PDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_wr,
    input  logic [PAW-1:0] start_addr,
    input  logic [PDW-1:0] start_wdata,
    output logic           busy,
    output logic           cur_wr,
    output logic [PAW-1:0] cur_addr,
    output logic           rd_done,
    output logic [PDW-1:0] rd_byte,
    output logic           phy_req,
    output logic           phy_we,
    output logic [PAW-1:0] phy_addr,
    output logic [PDW-1:0] phy_wdata,
    input  logic [PDW-1:0] phy_rdata,
    input  logic           phy_ready
);
    typedef struct packed {
        xfer_state_e    st;
        logic           wr;
        logic [PAW-1:0] addr;
        logic [PDW-1:0] wdat;
    } xfer_regs_t;

    xfer_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        rd_done = 1'b0;
        case (r_q.st)
            XS_IDLE: begin
                if (start) begin
                    r_d.st   = XS_WAIT;
                    r_d.wr   = start_wr;
                    r_d.addr = start_addr;
                    r_d.wdat = start_wdata;
                end
            end
            XS_WAIT: begin
                if (phy_ready) begin
                    r_d.st  = XS_TAIL;
                    rd_done = !r_q.wr;
                end
            end
            XS_TAIL: r_d.st = XS_IDLE;
            default: r_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: XS_IDLE, wr: 1'b0, addr: '0, wdat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != XS_IDLE);
    assign cur_wr    = r_q.wr;
    assign cur_addr  = r_q.addr;
    assign rd_byte   = phy_rdata;
    assign phy_req   = (r_q.st == XS_WAIT);
    assign phy_we    = r_q.wr;
    assign phy_addr  = r_q.addr;
    assign phy_wdata = r_q.wdat;

    // R6: request held with stable payload while the PHY stalls
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ready) |=> (phy_req && $stable(phy_addr)
                                     && $stable(phy_we) && $stable(phy_wdata)));

    // R7: request drops after the handshake, busy one cycle later
    assert_busy_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ready) |=> (busy && !phy_req) ##1 !busy);

    // R8: a command while busy leaves the latched command untouched
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(cur_addr) && $stable(cur_wr)));

    // R6: a request only starts from an accepted command
    assert_req_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_req) |-> $past(start));
endmodule

// File: rtl/phyb_bridge.sv
module phyb_bridge #(
    parameter int          BUS_AW   = 12,
    parameter int          BUS_DW   = 16,
    parameter int          PHY_AW   = 8,
    parameter int          PHY_DW   = 8,
    parameter logic [11:0] CMD_OFS  = 12'h300,
    parameter logic [11:0] DATA_OFS = 12'h304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [PHY_DW-1:0] phy_wdata,
    input  logic [PHY_DW-1:0] phy_rdata,
    input  logic              phy_ready
);
    localparam int WR_BIT   = PHY_AW;
    localparam int BUSY_BIT = PHY_AW + 1;

    logic              cmd_hit, data_hit, cmd_wr, data_wr;
    logic              busy, cur_wr, rd_done;
    logic [PHY_AW-1:0] cur_addr;
    logic [PHY_DW-1:0] rd_byte;
    logic [BUS_DW-1:0] data_d, data_q;
    logic [BUS_DW-1:0] cmd_word;

    phyb_decode #(
        .AW(BUS_AW), .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS)
    ) dec_i (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .cmd_hit (cmd_hit),
        .data_hit(data_hit),
        .cmd_wr  (cmd_wr),
        .data_wr (data_wr)
    );

    phyb_xfer_fsm #(.PAW(PHY_AW), .PDW(PHY_DW)) xfer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_wr),
        .start_wr   (bus_wdata[WR_BIT]),
        .start_addr (bus_wdata[PHY_AW-1:0]),
        .start_wdata(data_q[PHY_DW-1:0]),
        .busy       (busy),
        .cur_wr     (cur_wr),
        .cur_addr   (cur_addr),
        .rd_done    (rd_done),
        .rd_byte    (rd_byte),
        .phy_req    (phy_req),
        .phy_we     (phy_we),
        .phy_addr   (phy_addr),
        .phy_wdata  (phy_wdata),
        .phy_rdata  (phy_rdata),
        .phy_ready  (phy_ready)
    );

    always_comb begin
        data_d = data_q;
        if (rd_done) begin
            data_d               = '0;
            data_d[PHY_DW-1:0]   = rd_byte;
        end else if (data_wr) begin
            data_d = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    always_comb begin
        cmd_word                 = '0;
        cmd_word[PHY_AW-1:0]     = cur_addr;
        cmd_word[WR_BIT]         = cur_wr;
        cmd_word[BUSY_BIT]       = busy;
        if (cmd_hit)       bus_rdata = cmd_word;
        else if (data_hit) bus_rdata = data_q;
        else               bus_rdata = '0;
    end

    // R3: an accepted command shows busy on the next cycle
    assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    // R5: read completion lands in the low byte, upper byte zero
    assert_rd_land_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ready && !phy_we) |=>
            (data_q == BUS_DW'($past(phy_rdata))));

    // R9: unmapped writes leave the data register alone
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && !cmd_hit && !data_hit && !phy_req) |=> $stable(data_q));
endmodule

// File: tb/phyb_bridge_tb_top.sv
module phyb_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        phy_req, phy_we;
    logic [7:0]  phy_addr, phy_wdata;
    logic [7:0]  phy_rdata;
    logic        phy_ready = 1'b0;

    int tests = 0, fails = 0;
    int lat = 0, wait_cnt = 0;
    bit done = 0;

    // PHY register file model and reference model state
    logic [7:0]  mem [256];
    int          m_st;     // 0 idle, 1 waiting, 2 tail
    logic [7:0]  m_addr, m_wdat;
    logic        m_wr;
    logic [15:0] m_data;

    always #5 clk = ~clk;

    phyb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ready(phy_ready)
    );

    assign phy_rdata = phy_req ? mem[phy_addr] : 8'h00;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
        m_st = 0; m_addr = 0; m_wdat = 0; m_wr = 0; m_data = 0;
    end

    // PHY responder: ready after lat stall cycles
    always @(negedge clk) phy_ready <= phy_req && (wait_cnt >= lat);

    // Reference model and PHY storage, advanced at each rising edge
    always @(posedge clk) begin
        logic [15:0] old_data;
        if (phy_req && phy_ready) wait_cnt <= 0;
        else if (phy_req)         wait_cnt <= wait_cnt + 1;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_wdat = 0; m_wr = 0; m_data = 0;
        end else begin
            old_data = m_data;
            if (bus_sel && bus_we && bus_addr == 12'h304) m_data = bus_wdata;
            case (m_st)
                1: if (phy_ready) begin
                    if (m_wr) mem[m_addr] = m_wdat;
                    else      m_data = {8'h00, mem[m_addr]};
                    m_st = 2;
                end
                2: m_st = 0;
                default: if (bus_sel && bus_we && bus_addr == 12'h300) begin
                    m_addr = bus_wdata[7:0];
                    m_wr   = bus_wdata[8];
                    m_wdat = old_data[7:0];
                    m_st   = 1;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [15:0] exp_rd;
            if (bus_addr == 12'h300)      exp_rd = {6'b0, m_st != 0, m_wr, m_addr};
            else if (bus_addr == 12'h304) exp_rd = m_data;
            else                          exp_rd = 16'h0000;
            chk(bus_addr == 12'h300 ? "R3 cmd readback" :
                bus_addr == 12'h304 ? "R5 data readback" : "R9 unmapped readback",
                bus_rdata, exp_rd);
            chk("R6 phy_req", {15'b0, phy_req}, {15'b0, m_st == 1});
            if (m_st == 1) begin
                chk("R4 phy_we",    {15'b0, phy_we}, {15'b0, m_wr});
                chk("R4 phy_addr",  {8'h0, phy_addr},  {8'h0, m_addr});
                chk("R4 phy_wdata", {8'h0, phy_wdata}, {8'h0, m_wdat});
            end
        end
    end

    task automatic bwr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic brd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        bus_addr = 12'h300;
        #2;
        while (bus_rdata[9]) begin
            @(negedge clk);
            #2;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        brd(12'h300, 16'h0000, "R1 cmd reset");
        brd(12'h304, 16'h0000, "R1 data reset");
        chk("R1 phy_req reset", {15'b0, phy_req}, 16'h0);

        // R2 full-width data register
        bwr(12'h304, 16'hBEEF);
        brd(12'h304, 16'hBEEF, "R2 data store");

        // R4 write command, zero-latency PHY
        lat = 0;
        bwr(12'h304, 16'h77A5);
        bwr(12'h300, 16'h0112);
        brd(12'h300, 16'h0312, "R3 busy after write cmd");
        wait_idle();
        brd(12'h300, 16'h0112, "R7 busy cleared");
        chk("R4 phy stored byte", {8'h0, mem[8'h12]}, 16'h00A5);

        // R5 read command, three stall cycles
        lat = 3;
        bwr(12'h300, 16'h0012);
        wait_idle();
        brd(12'h304, 16'h00A5, "R5 read result");

        // R5 read of an untouched register, upper byte cleared
        bwr(12'h304, 16'hFFFF);
        bwr(12'h300, 16'h0040);
        wait_idle();
        brd(12'h304, 16'h0040 ^ 16'h003C, "R5 upper byte zero");

        // R8 command during busy is ignored
        lat = 6;
        bwr(12'h300, 16'h0055);
        bwr(12'h300, 16'h0199);
        brd(12'h300, 16'h0255, "R8 cmd kept while busy");
        wait_idle();
        brd(12'h300, 16'h0055, "R8 cmd after ignored write");
        chk("R8 no write to 0x99", {8'h0, mem[8'h99]}, {8'h0, 8'h99 ^ 8'h3C});

        // R3 busy bit written high is not stored as such; idle start works
        lat = 1;
        bwr(12'h304, 16'h0033);
        bwr(12'h300, 16'h03C0);
        wait_idle();
        brd(12'h300, 16'h01C0, "R3 busy bit read-only");
        chk("R4 write via bit8", {8'h0, mem[8'hC0]}, 16'h0033);

        // R9 unmapped offsets
        bwr(12'h308, 16'h1234);
        brd(12'h308, 16'h0000, "R9 unmapped read");
        brd(12'h304, 16'h0033, "R9 data unchanged");
        brd(12'h300, 16'h01C0, "R9 cmd unchanged");

        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule